// File: doc/BRIEF.md
# Dual-Phase Serial Frame Transmitter

This block sends one serial data frame on a start strobe. A frame has three parts in a fixed order: a low active phase, a high active phase and a passive phase. Each active phase shifts out its own 16-bit word, least significant bit first, with a bit count set separately for that phase. Each phase may also begin with one extra selection bit driven low. A separate enable output marks each active phase. A third enable, kept for command frames, never asserts during a data frame. The passive gap is programmable from 2 to 31 frame clock periods.

Timing is set by a single-cycle `tick` input, which marks the start of each frame clock period. Successive ticks must be at least two clock cycles apart. The frame clock `fclk` is a one-cycle high pulse on the tick that closes a slot; a receiver samples `sdo` on its rising edge. `sdo` and the enables change on the following clock edge, which is the falling edge of `fclk`. When `clk_ctl` is 0, `fclk` pulses only for active slots. When it is 1, it also pulses once for every passive slot. All configuration is captured on the accepted start. The end of the frame is reported by a one-cycle `irq` pulse.

Top module: `dpsf_tx`

## Requirements
- R1: The slots of a frame come in this order: low selection bit, low data, high selection bit, high data, passive gap. `en_lo` is high for every low-phase slot, `en_hi` is high for every high-phase slot, and the two are never high together.
- R2: The low phase sends `cnt_lo` data bits and the high phase sends `cnt_hi` data bits. Values from 0 to 16 are used as given; any value above 16 is treated as 16.
- R3: When `sel_lo_en` (or `sel_hi_en`) is 1, that phase starts with one extra slot in which `sdo` is 0 and the phase enable is high.
- R4: Each phase sends its data word starting at bit 0 and moving up one bit per slot.
- R5: `en_cmd` is 0 at all times.
- R6: The passive gap lasts G slots, where G = `gap_len` for values 2 to 31 and G = 2 for values 0 and 1. `irq` goes high in the cycle after tick number A+G+1, counted from the start strobe. A is the number of active slots.
- R7: With `clk_ctl` = 0, `fclk` pulses exactly once per active slot and never during the gap. With `clk_ctl` = 1, it also pulses exactly once per gap slot.
- R8: A phase with a bit count of 0 and its selection bit disabled is skipped entirely, and its enable never asserts during that frame.
- R9: `fclk` is high for exactly one clock cycle per pulse. `sdo` changes only on the edge that ends an `fclk` pulse. `sdo` is 0 whenever neither active enable is high.
- R10: `busy` is high from the cycle after the accepted start until the cycle in which `irq` pulses. `irq` is high for exactly one cycle per frame.
- R11: A start strobe while `busy` is high is ignored. Input changes after the accepted start do not affect the frame in progress.
- R12: While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse marking each frame clock period |
| start | input | 1 | Start strobe; accepted only when idle |
| data_lo | input | 16 | Word sent in the low active phase |
| data_hi | input | 16 | Word sent in the high active phase |
| cnt_lo | input | 5 | Low-phase bit count (values above 16 act as 16) |
| cnt_hi | input | 5 | High-phase bit count (values above 16 act as 16) |
| sel_lo_en | input | 1 | Low phase begins with a low selection bit |
| sel_hi_en | input | 1 | High phase begins with a low selection bit |
| gap_len | input | 5 | Passive gap length in frame clock periods (minimum 2) |
| clk_ctl | input | 1 | 0: frame clock only in active phases; 1: also in the gap |
| fclk | output | 1 | Frame clock pulse |
| sdo | output | 1 | Serial data output |
| en_lo | output | 1 | Low active phase enable |
| en_hi | output | 1 | High active phase enable |
| en_cmd | output | 1 | Command-frame enable, idle for data frames |
| busy | output | 1 | Frame in progress |
| irq | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench builds the block with its default parameters: 16-bit data words and 5-bit count and gap fields. The 5-bit fields reach bit counts from 17 to 31, so the clamp to 16 can be tested, as can the gap values 0 and 1 that clamp to 2 and the full 31-slot gap. With the full word width, a complete 16-bit phase with its selection bit is exercised, and random words show that each bit is placed correctly.

// File: rtl/dpsf_pkg.sv
package dpsf_pkg;
  typedef enum logic [2:0] {
    SL_IDLE,
    SL_ARM,
    SL_SEL_LO,
    SL_DAT_LO,
    SL_SEL_HI,
    SL_DAT_HI,
    SL_GAP
  } slot_e;
endpackage

// File: rtl/dpsf_seq.sv
module dpsf_seq
  import dpsf_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 5,
  parameter int GW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic [DW-1:0] data_lo,
  input  logic [DW-1:0] data_hi,
  input  logic [CW-1:0] cnt_lo,
  input  logic [CW-1:0] cnt_hi,
  input  logic          sel_lo_en,
  input  logic          sel_hi_en,
  input  logic [GW-1:0] gap_len,
  input  logic          clk_ctl,
  output slot_e         slot_o,
  output logic          bit_o,
  output logic          ctl_o,
  output logic          busy_o,
  output logic          irq_o
);
  localparam int IW = (CW > GW) ? CW : GW;
  localparam int SW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [IW-1:0] MAXB = IW'(DW);
  localparam logic [IW-1:0] MINGAP = IW'(2);

  slot_e          slot_q, slot_n;
  logic [IW-1:0]  idx_q, idx_n;
  logic           irq_q, irq_n;
  logic           load;
  logic [DW-1:0]  data_lo_q, data_hi_q;
  logic [IW-1:0]  nlo_q, nhi_q, gap_q;
  logic           sel_lo_q, sel_hi_q, ctl_q;
  logic [IW-1:0]  nlo_in, nhi_in, gap_in, idx_inc;
  slot_e          hi_entry, lo_entry;

  // clamp configuration fields on the way into the capture registers
  always_comb begin
    nlo_in = (IW'(cnt_lo) > MAXB) ? MAXB : IW'(cnt_lo);
    nhi_in = (IW'(cnt_hi) > MAXB) ? MAXB : IW'(cnt_hi);
    gap_in = (IW'(gap_len) < MINGAP) ? MINGAP : IW'(gap_len);
  end

  // first slot of each phase, falling through empty phases
  always_comb begin
    if (sel_hi_q)            hi_entry = SL_SEL_HI;
    else if (nhi_q != '0)    hi_entry = SL_DAT_HI;
    else                     hi_entry = SL_GAP;
    if (sel_lo_q)            lo_entry = SL_SEL_LO;
    else if (nlo_q != '0)    lo_entry = SL_DAT_LO;
    else                     lo_entry = hi_entry;
  end

  assign idx_inc = idx_q + IW'(1);

  // next-state logic
  always_comb begin
    slot_n = slot_q;
    idx_n  = idx_q;
    irq_n  = 1'b0;
    load   = 1'b0;
    if (slot_q == SL_IDLE) begin
      if (start) begin
        slot_n = SL_ARM;
        idx_n  = '0;
        load   = 1'b1;
      end
    end else if (tick) begin
      idx_n = '0;
      case (slot_q)
        SL_ARM:    slot_n = lo_entry;
        SL_SEL_LO: slot_n = (nlo_q != '0) ? SL_DAT_LO : hi_entry;
        SL_DAT_LO: begin
          if (idx_inc < nlo_q) idx_n = idx_inc;
          else                 slot_n = hi_entry;
        end
        SL_SEL_HI: slot_n = (nhi_q != '0) ? SL_DAT_HI : SL_GAP;
        SL_DAT_HI: begin
          if (idx_inc < nhi_q) idx_n = idx_inc;
          else                 slot_n = SL_GAP;
        end
        SL_GAP: begin
          if (idx_inc < gap_q) idx_n = idx_inc;
          else begin
            slot_n = SL_IDLE;
            irq_n  = 1'b1;
          end
        end
        default: slot_n = SL_IDLE;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= SL_IDLE;
      idx_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      slot_q <= slot_n;
      idx_q  <= idx_n;
      irq_q  <= irq_n;
    end
  end

  // configuration capture, enabled only by an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_lo_q <= '0;
      data_hi_q <= '0;
      nlo_q     <= '0;
      nhi_q     <= '0;
      gap_q     <= MINGAP;
      sel_lo_q  <= 1'b0;
      sel_hi_q  <= 1'b0;
      ctl_q     <= 1'b0;
    end else if (load) begin
      data_lo_q <= data_lo;
      data_hi_q <= data_hi;
      nlo_q     <= nlo_in;
      nhi_q     <= nhi_in;
      gap_q     <= gap_in;
      sel_lo_q  <= sel_lo_en;
      sel_hi_q  <= sel_hi_en;
      ctl_q     <= clk_ctl;
    end
  end

  always_comb begin
    case (slot_q)
      SL_DAT_LO: bit_o = data_lo_q[idx_q[SW-1:0]];
      SL_DAT_HI: bit_o = data_hi_q[idx_q[SW-1:0]];
      default:   bit_o = 1'b0;
    endcase
  end

  assign slot_o = slot_q;
  assign ctl_o  = ctl_q;
  assign busy_o = (slot_q != SL_IDLE);
  assign irq_o  = irq_q;

  // R2
  dat_lo_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q == SL_DAT_LO) |-> (idx_q < nlo_q && nlo_q <= MAXB));
  // R2
  dat_hi_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q == SL_DAT_HI) |-> (idx_q < nhi_q && nhi_q <= MAXB));
  // R6
  gap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q == SL_GAP) |-> (idx_q < gap_q && gap_q >= MINGAP));
  // R1
  phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q inside {SL_SEL_HI, SL_DAT_HI, SL_GAP}) |=>
      !(slot_q inside {SL_SEL_LO, SL_DAT_LO, SL_ARM}));
  // R10
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q != SL_IDLE) |=> ($stable(data_lo_q) && $stable(data_hi_q) &&
      $stable(nlo_q) && $stable(nhi_q) && $stable(gap_q) && $stable(ctl_q)));
endmodule

// File: rtl/dpsf_out.sv
module dpsf_out
  import dpsf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  slot_e slot_i,
  input  logic  bit_i,
  input  logic  ctl_i,
  output logic  fclk_o,
  output logic  sdo_o,
  output logic  en_lo_o,
  output logic  en_hi_o
);
  logic tick_q;
  logic sdo_q, enl_q, enh_q, gap_q, fclk_q;
  logic sdo_n, enl_n, enh_n, gap_n, fclk_n;

  // slot outputs follow the sequencer one cycle after a tick (fclk falling)
  always_comb begin
    sdo_n  = sdo_q;
    enl_n  = enl_q;
    enh_n  = enh_q;
    gap_n  = gap_q;
    if (tick_q) begin
      enl_n = (slot_i == SL_SEL_LO) || (slot_i == SL_DAT_LO);
      enh_n = (slot_i == SL_SEL_HI) || (slot_i == SL_DAT_HI);
      gap_n = (slot_i == SL_GAP);
      sdo_n = bit_i;
    end
    fclk_n = tick && (enl_q || enh_q || (ctl_i && gap_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
      sdo_q  <= 1'b0;
      enl_q  <= 1'b0;
      enh_q  <= 1'b0;
      gap_q  <= 1'b0;
      fclk_q <= 1'b0;
    end else begin
      tick_q <= tick;
      sdo_q  <= sdo_n;
      enl_q  <= enl_n;
      enh_q  <= enh_n;
      gap_q  <= gap_n;
      fclk_q <= fclk_n;
    end
  end

  assign fclk_o  = fclk_q;
  assign sdo_o   = sdo_q;
  assign en_lo_o = enl_q;
  assign en_hi_o = enh_q;

  // R1
  en_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(enl_q && enh_q));
  // R9
  sdo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(enl_q || enh_q) |-> !sdo_q);
  // R9
  sdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_q) |-> $past(tick_q));
  // R7
  fclk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fclk_q && !ctl_i) |-> (enl_q || enh_q));
endmodule

// File: rtl/dpsf_tx.sv
module dpsf_tx
  import dpsf_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 5,
  parameter int GW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic [DW-1:0] data_lo,
  input  logic [DW-1:0] data_hi,
  input  logic [CW-1:0] cnt_lo,
  input  logic [CW-1:0] cnt_hi,
  input  logic          sel_lo_en,
  input  logic          sel_hi_en,
  input  logic [GW-1:0] gap_len,
  input  logic          clk_ctl,
  output logic          fclk,
  output logic          sdo,
  output logic          en_lo,
  output logic          en_hi,
  output logic          en_cmd,
  output logic          busy,
  output logic          irq
);
  logic [1:0] rsync_q;
  logic       rst_int_n;
  slot_e      slot;
  logic       cur_bit, ctl;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  dpsf_seq #(.DW(DW), .CW(CW), .GW(GW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tick      (tick),
    .start     (start),
    .data_lo   (data_lo),
    .data_hi   (data_hi),
    .cnt_lo    (cnt_lo),
    .cnt_hi    (cnt_hi),
    .sel_lo_en (sel_lo_en),
    .sel_hi_en (sel_hi_en),
    .gap_len   (gap_len),
    .clk_ctl   (clk_ctl),
    .slot_o    (slot),
    .bit_o     (cur_bit),
    .ctl_o     (ctl),
    .busy_o    (busy),
    .irq_o     (irq)
  );

  dpsf_out u_out (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick    (tick),
    .slot_i  (slot),
    .bit_i   (cur_bit),
    .ctl_i   (ctl),
    .fclk_o  (fclk),
    .sdo_o   (sdo),
    .en_lo_o (en_lo),
    .en_hi_o (en_hi)
  );

  // data frames never use the command enable
  assign en_cmd = 1'b0;

  // R10
  busy_irq_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq |-> !busy);
endmodule

// File: tb/dpsf_tx_bench.sv
`timescale 1ns/1ps
module dpsf_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n, tick, start;
  logic [15:0] data_lo, data_hi;
  logic [4:0]  cnt_lo, cnt_hi, gap_len;
  logic        sel_lo_en, sel_hi_en, clk_ctl;
  logic        fclk, sdo, en_lo, en_hi, en_cmd, busy, irq;

  always #4 clk = ~clk;

  dpsf_tx u_dpsf_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
    .data_lo(data_lo), .data_hi(data_hi), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
    .sel_lo_en(sel_lo_en), .sel_hi_en(sel_hi_en), .gap_len(gap_len),
    .clk_ctl(clk_ctl), .fclk(fclk), .sdo(sdo), .en_lo(en_lo), .en_hi(en_hi),
    .en_cmd(en_cmd), .busy(busy), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  int tcyc = 0;

  // monitor state
  bit track = 0;
  int n_act, n_gap, irq_cnt, irq_tick, tick_cnt;
  int cmd_bad, sdo_bad, both_bad, wide_bad, lo_seen, hi_seen;
  bit prev_fclk = 0;
  int cap_lo[80], cap_hi[80], cap_d[80];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int clamp_cnt(input int c);
    return (c > 16) ? 16 : c;
  endfunction

  function automatic int clamp_gap(input int g);
    return (g < 2) ? 2 : g;
  endfunction

  // tick: one cycle high out of every four
  initial begin
    tick = 1'b0;
    forever begin
      @(negedge clk);
      tcyc++;
      tick = (tcyc % 4 == 0);
    end
  end

  always @(posedge clk) if (track && tick) tick_cnt++;

  always @(negedge clk) begin
    if (track) begin
      if (fclk) begin
        if (en_lo || en_hi) begin
          if (n_act < 80) begin
            cap_lo[n_act] = int'(en_lo);
            cap_hi[n_act] = int'(en_hi);
            cap_d[n_act]  = int'(sdo);
          end
          n_act++;
        end else n_gap++;
        if (prev_fclk) wide_bad++;
      end
      if (irq) begin irq_cnt++; irq_tick = tick_cnt; end
      if (en_cmd) cmd_bad++;
      if (!en_lo && !en_hi && sdo) sdo_bad++;
      if (en_lo && en_hi) both_bad++;
      if (en_lo) lo_seen++;
      if (en_hi) hi_seen++;
    end
    prev_fclk = fclk;
  end

  task automatic run_frame(input logic [15:0] dl, input logic [15:0] dh,
                           input int cl, input int ch, input bit sl, input bit sh,
                           input int gp, input bit ctl, input bit poke);
    int e_lo[80], e_hi[80], e_d[80];
    int a, g, nl, nh, bad, first;
    data_lo = dl; data_hi = dh; cnt_lo = 5'(cl); cnt_hi = 5'(ch);
    sel_lo_en = sl; sel_hi_en = sh; gap_len = 5'(gp); clk_ctl = ctl;
    n_act = 0; n_gap = 0; irq_cnt = 0; irq_tick = -1; tick_cnt = 0;
    cmd_bad = 0; sdo_bad = 0; both_bad = 0; wide_bad = 0; lo_seen = 0; hi_seen = 0;
    @(posedge clk iff tick);
    @(negedge clk);
    track = 1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R10", "busy after start", int'(busy), 1);
    if (poke) begin
      repeat (5) @(posedge clk iff tick);
      @(negedge clk);
      data_lo = ~dl; data_hi = ~dh; cnt_lo = 5'd1; cnt_hi = 5'd1;
      sel_lo_en = ~sl; sel_hi_en = ~sh; gap_len = 5'd9; clk_ctl = ~ctl;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 600 && irq_cnt == 0; i++) @(negedge clk);
    chk(busy === 1'b0, "R10", "busy at irq", int'(busy), 0);
    repeat (poke ? 320 : 12) @(negedge clk);
    track = 0;
    // expected slot list
    nl = clamp_cnt(cl); nh = clamp_cnt(ch); g = clamp_gap(gp); a = 0;
    if (sl) begin e_lo[a] = 1; e_hi[a] = 0; e_d[a] = 0; a++; end
    for (int i = 0; i < nl; i++) begin e_lo[a] = 1; e_hi[a] = 0; e_d[a] = int'(dl[i]); a++; end
    if (sh) begin e_lo[a] = 0; e_hi[a] = 1; e_d[a] = 0; a++; end
    for (int i = 0; i < nh; i++) begin e_lo[a] = 0; e_hi[a] = 1; e_d[a] = int'(dh[i]); a++; end
    chk(n_act == a, "R2", "active slot count", n_act, a);
    bad = 0; first = -1;
    for (int i = 0; i < a && i < n_act; i++)
      if (cap_lo[i] != e_lo[i] || cap_hi[i] != e_hi[i] || cap_d[i] != e_d[i]) begin
        bad++; if (first < 0) first = i;
      end
    // R1 R3 R4: order, enables, selection bits and bit order of every slot
    chk(bad == 0, "R4", "mismatching slots (order/enable/data)", bad, 0);
    if (first >= 0)
      $display("  first bad slot %0d: en_lo %0d/%0d en_hi %0d/%0d sdo %0d/%0d", first,
               cap_lo[first], e_lo[first], cap_hi[first], e_hi[first], cap_d[first], e_d[first]);
    chk(n_gap == (ctl ? g : 0), "R7", "gap clock pulses", n_gap, ctl ? g : 0);
    chk(irq_tick == a + g + 1, "R6", "ticks until irq", irq_tick, a + g + 1);
    chk(irq_cnt == 1, "R10", "irq pulses", irq_cnt, 1);
    chk(cmd_bad == 0, "R5", "en_cmd high cycles", cmd_bad, 0);
    chk(sdo_bad == 0 && wide_bad == 0, "R9", "sdo outside phase / wide fclk", sdo_bad + wide_bad, 0);
    chk(both_bad == 0, "R1", "both enables high", both_bad, 0);
    if (nl == 0 && !sl) chk(lo_seen == 0, "R8", "en_lo cycles in skipped phase", lo_seen, 0);
    if (nh == 0 && !sh) chk(hi_seen == 0, "R8", "en_hi cycles in skipped phase", hi_seen, 0);
    if (poke) chk(irq_cnt == 1 && n_act == a, "R11", "restart during frame", irq_cnt, 1);
  endtask

  initial begin
    #1200000;
    checks++; errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; start = 1'b0;
    data_lo = '0; data_hi = '0; cnt_lo = '0; cnt_hi = '0;
    sel_lo_en = 0; sel_hi_en = 0; gap_len = '0; clk_ctl = 0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk({fclk, sdo, en_lo, en_hi, en_cmd, busy, irq} === 7'b0, "R12", "outputs in reset",
        int'({fclk, sdo, en_lo, en_hi, en_cmd, busy, irq}), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk({fclk, sdo, en_lo, en_hi, busy, irq} === 6'b0, "R12", "outputs after reset",
        int'({fclk, sdo, en_lo, en_hi, busy, irq}), 0);
    // directed corner cases
    run_frame(16'hA5C3, 16'h3C5A, 16, 16, 1, 1, 31, 1, 0); // R3 full phases, max gap
    run_frame(16'h0000, 16'h0005, 0, 3, 0, 0, 4, 0, 0);    // R8 low phase skipped
    run_frame(16'hFFFF, 16'hFFFF, 0, 0, 0, 0, 0, 1, 0);    // R8 R6 empty frame, gap clamp
    run_frame(16'h1234, 16'hFEDC, 31, 17, 0, 1, 1, 0, 0);  // R2 count clamp, R6 gap 1
    run_frame(16'h8001, 16'h0000, 5, 0, 1, 1, 2, 1, 0);    // R3 selection with no data
    run_frame(16'h6C93, 16'h19E4, 7, 9, 1, 0, 6, 0, 1);    // R11 restart ignored
    // constrained random frames
    for (int f = 0; f < 25; f++)
      run_frame(16'($urandom), 16'($urandom), int'($urandom % 20), int'($urandom % 20),
                1'($urandom), 1'($urandom), int'($urandom % 32), 1'($urandom), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule